// File: doc/BRIEF.md
# Conditional-Sum Adder/Subtractor

This block adds or subtracts two N-bit two's-complement operands in pure combinational logic. Rather than letting a carry ripple across the full word, it splits the word into halves again and again until each piece is a 2-bit ripple adder. Every piece works out its result twice, once assuming an incoming carry of 0 and once assuming 1. At each level of the split, the lower half's carries pick between the upper half's two results through 2:1 multiplexers. The carry path through the word is therefore log2(N) multiplexer stages plus one short leaf ripple.

Subtraction uses the same datapath. The second operand is bit-inverted, and the carry entering the least-significant position is inverted too. With a carry-in of 0, this makes the block compute A - B. A carry-in of 1 then acts as a borrow and gives A - B - 1, so words can be chained. The outputs are the N-bit result, the unsigned carry out of the top bit, and a signed overflow flag.

Top module: `cond_sum_addsub`

## Requirements
- R1: With sub_i = 0, sum_o equals (a_i + b_i + cin_i) modulo 2^N.
- R2: With sub_i = 1, sum_o equals (a_i - b_i - cin_i) modulo 2^N, so cin_i acts as a borrow.
- R3: With sub_i = 0, ovf_o is 1 exactly when the signed sum a_i + b_i + cin_i lies outside [-2^(N-1), 2^(N-1)-1].
- R4: With sub_i = 1, ovf_o is 1 exactly when the signed difference a_i - b_i - cin_i lies outside [-2^(N-1), 2^(N-1)-1].
- R5: cout_o is bit N of a_i + (b_i, inverted when sub_i = 1) + (cin_i XOR sub_i). For addition, this is 1 when the unsigned sum reaches 2^N. For subtraction, it is 1 when unsigned a_i >= b_i + cin_i, meaning no borrow.
- R6: Negative operands need no special treatment. All-ones plus one gives zero with cout_o = 1 and ovf_o = 0. All-ones plus all-ones gives all-ones minus one with cout_o = 1 and ovf_o = 0.
- R7: The extremes behave as follows. The largest positive value plus one gives the most negative value with ovf_o = 1. The most negative value minus one gives the largest positive value with ovf_o = 1. Zero minus the most negative value gives the most negative value with ovf_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, two's complement |
| b_i | input | N | Second operand, two's complement |
| sub_i | input | 1 | 1 = subtract b_i from a_i, 0 = add |
| cin_i | input | 1 | Carry-in for addition, borrow-in for subtraction |
| sum_o | output | N | Result modulo 2^N |
| cout_o | output | 1 | Unsigned carry out of the most significant bit |
| ovf_o | output | 1 | Signed overflow |

## Verification
Some relations are checked by immediate assertions every time the inputs change. At every segment of the tree, the carry-1 alternative must be exactly one more than the carry-0 alternative. At the top, the addition and subtraction results must match their arithmetic definitions. The overflow flag, which is built from the operand signs, must agree with the carry entering the sign bit XORed with the carry leaving it. The bench's scenarios are needed for the rest: the cases where the signed result falls outside the representable range, the borrow meaning of cout_o for subtraction, and the extreme values. These are checked against signed and unsigned integer arithmetic computed in the bench.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned CSA_LEAF_W    = 2;
  localparam int unsigned CSA_DEFAULT_N = 16;
endpackage

// File: rtl/csa_leaf.sv
module csa_leaf #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s0_o,
  output logic         c0_o,
  output logic [W-1:0] s1_o,
  output logic         c1_o
);
  logic cr0, cr1;

  always_comb begin
    cr0 = 1'b0;
    cr1 = 1'b1;
    for (int i = 0; i < int'(W); i++) begin
      s0_o[i] = a_i[i] ^ b_i[i] ^ cr0;
      s1_o[i] = a_i[i] ^ b_i[i] ^ cr1;
      cr0 = (a_i[i] & b_i[i]) | (a_i[i] & cr0) | (b_i[i] & cr0);
      cr1 = (a_i[i] & b_i[i]) | (a_i[i] & cr1) | (b_i[i] & cr1);
    end
    c0_o = cr0;
    c1_o = cr1;
  end

  // R1: the ripple result with carry 0 is the plain sum
  always_comb begin
    a_r1_leaf_sum: assert ({c0_o, s0_o} == ({1'b0, a_i} + {1'b0, b_i}))
      else $error("leaf carry-0 alternative wrong");
  end
endmodule

// File: rtl/csa_node.sv
module csa_node #(
  parameter int unsigned W      = 16,
  parameter int unsigned LEAF_W = csa_pkg::CSA_LEAF_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s0_o,
  output logic         c0_o,
  output logic [W-1:0] s1_o,
  output logic         c1_o
);
  localparam int unsigned HW = W / 2;

  generate
    if (W <= LEAF_W) begin : g_leaf
      csa_leaf #(.W(W)) u_leaf (
        .a_i(a_i), .b_i(b_i),
        .s0_o(s0_o), .c0_o(c0_o), .s1_o(s1_o), .c1_o(c1_o)
      );
    end else begin : g_split
      logic [HW-1:0] lo_s0, lo_s1, hi_s0, hi_s1;
      logic          lo_c0, lo_c1, hi_c0, hi_c1;

      csa_node #(.W(HW), .LEAF_W(LEAF_W)) u_lo (
        .a_i(a_i[HW-1:0]), .b_i(b_i[HW-1:0]),
        .s0_o(lo_s0), .c0_o(lo_c0), .s1_o(lo_s1), .c1_o(lo_c1)
      );
      csa_node #(.W(W-HW), .LEAF_W(LEAF_W)) u_hi (
        .a_i(a_i[W-1:HW]), .b_i(b_i[W-1:HW]),
        .s0_o(hi_s0), .c0_o(hi_c0), .s1_o(hi_s1), .c1_o(hi_c1)
      );

      // lower half's carry steers the upper half's precomputed pair
      always_comb begin
        s0_o = {(lo_c0 ? hi_s1 : hi_s0), lo_s0};
        c0_o = lo_c0 ? hi_c1 : hi_c0;
        s1_o = {(lo_c1 ? hi_s1 : hi_s0), lo_s1};
        c1_o = lo_c1 ? hi_c1 : hi_c0;
      end
    end
  endgenerate

  // R1: the carry-1 alternative is one above the carry-0 alternative
  always_comb begin
    a_r1_node_alt: assert ({c1_o, s1_o} == ({c0_o, s0_o} + (W+1)'(1)))
      else $error("segment alternatives inconsistent");
  end
endmodule

// File: rtl/cond_sum_addsub.sv
module cond_sum_addsub #(
  parameter int unsigned N = csa_pkg::CSA_DEFAULT_N
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int unsigned MSB = N - 1;

  logic [N-1:0] b_eff;
  logic         c_lsb;
  logic [N-1:0] r_s0, r_s1;
  logic         r_c0, r_c1;

  always_comb begin
    b_eff = b_i ^ {N{sub_i}};
    c_lsb = cin_i ^ sub_i;
  end

  csa_node #(.W(N), .LEAF_W(csa_pkg::CSA_LEAF_W)) u_root (
    .a_i(a_i), .b_i(b_eff),
    .s0_o(r_s0), .c0_o(r_c0), .s1_o(r_s1), .c1_o(r_c1)
  );

  always_comb begin
    sum_o  = c_lsb ? r_s1 : r_s0;
    cout_o = c_lsb ? r_c1 : r_c0;
    ovf_o  = ~(a_i[MSB] ^ b_eff[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
  end

  always_comb begin
    // R1 / R5: addition result and carry out
    if (!sub_i) begin
      a_r1_add_sum: assert ({cout_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + (N+1)'(cin_i)))
        else $error("add result wrong");
    end
    // R2: subtraction result with borrow
    if (sub_i) begin
      a_r2_sub_sum: assert (sum_o == (a_i - b_i - N'(cin_i)))
        else $error("subtract result wrong");
    end
    // R3 / R4: sign rule equals carry into sign bit XOR carry out
    a_r3_ovf_carry: assert (ovf_o ==
                            ((sum_o[MSB] ^ a_i[MSB] ^ b_eff[MSB]) ^ cout_o))
      else $error("overflow disagrees with sign carries");
  end
endmodule

// File: tb/sim_cond_sum_addsub.sv
module sim_cond_sum_addsub;
  localparam int N = 16;

  logic clk;
  logic rst_n;
  logic [N-1:0] a, b;
  logic sub, cin;
  logic [N-1:0] sum;
  logic cout, ovf;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  cond_sum_addsub #(.N(N)) u0 (
    .a_i(a), .b_i(b), .sub_i(sub), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [N-1:0] exp_sum(logic [N-1:0] x, logic [N-1:0] y, logic s, logic c);
    longint r;
    r = s ? (longint'(x) - longint'(y) - longint'(c)) : (longint'(x) + longint'(y) + longint'(c));
    return r[N-1:0];
  endfunction

  function automatic logic exp_cout(logic [N-1:0] x, logic [N-1:0] y, logic s, logic c);
    if (s) return (longint'(x) >= longint'(y) + longint'(c));
    return (longint'(x) + longint'(y) + longint'(c)) >= (longint'(1) << N);
  endfunction

  function automatic logic exp_ovf(logic [N-1:0] x, logic [N-1:0] y, logic s, logic c);
    longint sx, sy, r;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    r = s ? (sx - sy - longint'(c)) : (sx + sy + longint'(c));
    return (r > ((longint'(1) << (N-1)) - 1)) || (r < -(longint'(1) << (N-1)));
  endfunction

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y,
                       input logic s, input logic c, input string tag);
    logic [N-1:0] es;
    logic ec, eo;
    @(negedge clk);
    a = x; b = y; sub = s; cin = c;
    #5;
    es = exp_sum(x, y, s, c);
    ec = exp_cout(x, y, s, c);
    eo = exp_ovf(x, y, s, c);
    n_cmp++;
    if (sum !== es) begin
      n_bad++;
      $display("FAIL %s sum a=%h b=%h sub=%0d cin=%0d actual=%h expected=%h", tag, x, y, s, c, sum, es);
    end
    n_cmp++;
    if (cout !== ec) begin
      n_bad++;
      $display("FAIL R5 cout a=%h b=%h sub=%0d cin=%0d actual=%0d expected=%0d", x, y, s, c, cout, ec);
    end
    n_cmp++;
    if (ovf !== eo) begin
      n_bad++;
      $display("FAIL %s ovf a=%h b=%h sub=%0d cin=%0d actual=%0d expected=%0d",
               s ? "R4" : "R3", x, y, s, c, ovf, eo);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp_v, input string tag);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  localparam logic [N-1:0] MAXP = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] MINN = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ONES = {N{1'b1}};

  initial begin
    logic [N-1:0] corners [4];
    int seed;
    rst_n = 1'b0; a = '0; b = '0; sub = 1'b0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero inputs give zero outputs (R1)
    apply('0, '0, 1'b0, 1'b0, "R1");
    // R6: negative operands
    apply(ONES, 16'h0001, 1'b0, 1'b0, "R6");
    check_bit(cout, 1'b1, "R6 cout");
    check_bit(ovf, 1'b0, "R6 ovf");
    apply(ONES, ONES, 1'b0, 1'b0, "R6");
    // R7: extremes
    apply(MAXP, 16'h0001, 1'b0, 1'b0, "R7");
    check_bit(ovf, 1'b1, "R7 max+1 ovf");
    apply(MINN, 16'h0001, 1'b1, 1'b0, "R7");
    check_bit(ovf, 1'b1, "R7 min-1 ovf");
    apply('0, MINN, 1'b1, 1'b0, "R7");
    check_bit(ovf, 1'b1, "R7 0-min ovf");
    // R2 borrow and R5 no-borrow carry
    apply(16'h1234, 16'h1234, 1'b1, 1'b0, "R2");
    check_bit(cout, 1'b1, "R5 equal sub cout");
    apply(16'h1234, 16'h1234, 1'b1, 1'b1, "R2");
    check_bit(cout, 1'b0, "R5 borrow cout");
    // R1..R7: every corner pair, both ops, both carries
    corners[0] = MINN; corners[1] = ONES; corners[2] = '0; corners[3] = MAXP;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          apply(corners[i], corners[j], k[1], k[0], k[1] ? "R2" : "R1");
    // random vectors, fixed seed (R1, R2)
    seed = 32'h5eed_0c5a;
    void'($urandom(seed));
    for (int i = 0; i < 2000; i++) begin
      logic [N-1:0] ra, rb;
      logic rs, rc;
      ra = N'($urandom);
      rb = N'($urandom);
      rs = 1'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rs, rc, rs ? "R2" : "R1");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule